// File: doc/BRIEF.md
# Condition Evaluator and Skip Mask

This block decides whether a branch or skip condition holds, given the four arithmetic flags (negative, zero, carry, overflow) and a 4-bit condition code. Three bits of the code choose a predicate built from the flags. The fourth bit gives the polarity that the predicate must match. The code that selects the constant predicate therefore yields "never" or "always".

The block also keeps an 8-bit pending-skip mask. Each bit stands for one of the next eight instructions, and a set bit cancels that instruction as it issues. The mask advances by one place for every real instruction that issues. Words that only carry an extended immediate do not advance it. A SKIP instruction whose condition holds ORs its own 8-bit field into the mask. Chaining several SKIPs therefore builds compound AND and OR predicates. Any branch or jump empties the mask.

Top module: `skip_cond_unit`

## Requirements
- R1: While rst_ni is low and after its release, mask_o is all zeros.
- R2: cond_i[3:1] selects a predicate: 0 Z, 1 C, 2 N, 3 V, 4 N xor V, 5 Z or (N xor V), 6 Z or not C. cond_true_o is 1 exactly when that predicate equals cond_i[0]. The output is combinational and depends only on cond_i and the flags.
- R3: cond_i[3:1] = 7 is the constant-true predicate: code 4'b1110 gives cond_true_o = 0 and code 4'b1111 gives cond_true_o = 1, whatever the flags.
- R4: An issued instruction (issue_i = 1, ext_word_i = 0) that is not a SKIP, branch or jump moves the mask one place toward bit 0 at the next clock. Bit i+1 goes to bit i and bit 7 becomes 0.
- R5: mask_o[0] refers to the instruction now issuing. cancel_o equals 1 in the same cycle exactly when issue_i = 1, ext_word_i = 0 and mask_o[0] = 1.
- R6: kind_i encodes 0 plain, 1 SKIP, 2 branch, 3 jump. When an uncancelled SKIP issues with a true condition, the next mask is the shifted mask ORed with skip_field_i. Field bit 0 names the first instruction after the SKIP. When the condition is false, the mask only shifts.
- R7: An uncancelled branch or jump that issues clears the whole mask at the next clock, whether or not its condition holds.
- R8: A cycle with issue_i = 1 and ext_word_i = 1 is an extension word. It leaves the mask unchanged and keeps cancel_o at 0.
- R9: A cancelled instruction still shifts the mask. It neither ORs in its skip field nor clears the mask.
- R10: When issue_i = 0, the mask holds its value and cancel_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | A word is issuing this cycle |
| ext_word_i | input | 1 | The issuing word is an immediate extension word |
| kind_i | input | 2 | Instruction kind: 0 plain, 1 SKIP, 2 branch, 3 jump |
| cond_i | input | 4 | Condition code: [3:1] predicate select, [0] polarity |
| skip_field_i | input | 8 | Skip field of a SKIP instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| cond_true_o | output | 1 | The selected condition holds |
| cancel_o | output | 1 | The issuing instruction is turned into a no-op |
| mask_o | output | 8 | Current pending-skip mask |

## Verification
The hardest case is a SKIP that is itself cancelled by an earlier SKIP. Its condition is true and its field is non-zero, so a faulty design would visibly OR the field in. The bench reaches this case with directed sequences. A first SKIP sets bit 0 so that a second, true SKIP is the next instruction to issue. A compound AND chain is built the same way. Extension words are placed between links of the chain to confirm that they do not move the window. A long random stream then runs against a behavioural model.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned CODE_W = SEL_W + 1;
  localparam int unsigned NPRED  = 1 << SEL_W;

  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'd0,
    KIND_SKIP   = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_JUMP   = 2'd3
  } instr_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
  import skip_pkg::*;
(
  input  flags_t              flags_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic                hit_o
);
  logic [NPRED-1:0]  pred;
  logic [SEL_W-1:0]  sel;
  logic              pol;
  logic              lt;

  assign sel = code_i[CODE_W-1:1];
  assign pol = code_i[0];
  assign lt  = flags_i.n ^ flags_i.v;

  // predicate table indexed by sel
  assign pred[0] = flags_i.z;
  assign pred[1] = flags_i.c;
  assign pred[2] = flags_i.n;
  assign pred[3] = flags_i.v;
  assign pred[4] = lt;
  assign pred[5] = flags_i.z | lt;
  assign pred[6] = flags_i.z | ~flags_i.c;
  assign pred[7] = 1'b1;

  assign hit_o = (pred[sel] == pol);
endmodule

// File: rtl/skip_mask_reg.sv
module skip_mask_reg #(
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  input  logic              merge_i,
  input  logic              clear_i,
  input  logic [MASK_W-1:0] field_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              head_o
);
  logic [MASK_W-1:0] mask_q;
  logic [MASK_W-1:0] mask_d;
  logic [MASK_W-1:0] shifted;

  // per-slot next state: slot i takes slot i+1 on advance
  for (genvar i = 0; i < MASK_W; i++) begin : g_slot
    if (i == MASK_W - 1) begin : g_top
      assign shifted[i] = 1'b0;
    end else begin : g_mid
      assign shifted[i] = mask_q[i+1];
    end

    always_comb begin
      if (!advance_i)   mask_d[i] = mask_q[i];
      else if (clear_i) mask_d[i] = 1'b0;
      else if (merge_i) mask_d[i] = shifted[i] | field_i[i];
      else              mask_d[i] = shifted[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[i] <= 1'b0;
      else         mask_q[i] <= mask_d[i];
    end
  end

  assign mask_o = mask_q;
  assign head_o = mask_q[0];
endmodule

// File: rtl/skip_cond_unit.sv
module skip_cond_unit
  import skip_pkg::*;
#(
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              ext_word_i,
  input  logic [1:0]        kind_i,
  input  logic [3:0]        cond_i,
  input  logic [MASK_W-1:0] skip_field_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  input  logic              flag_v_i,
  output logic              cond_true_o,
  output logic              cancel_o,
  output logic [MASK_W-1:0] mask_o
);
  flags_t      flags;
  instr_kind_e kind;
  logic        hit;
  logic        real_issue;
  logic        head;
  logic        live;
  logic        is_flow;

  assign flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};
  assign kind  = instr_kind_e'(kind_i);

  skip_cond_eval u_eval (
    .flags_i (flags),
    .code_i  (cond_i),
    .hit_o   (hit)
  );

  assign real_issue = issue_i & ~ext_word_i;
  assign live       = real_issue & ~head;
  assign is_flow    = (kind == KIND_BRANCH) || (kind == KIND_JUMP);

  skip_mask_reg #(.MASK_W(MASK_W)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (real_issue),
    .merge_i   (live & (kind == KIND_SKIP) & hit),
    .clear_i   (live & is_flow),
    .field_i   (skip_field_i),
    .mask_o    (mask_o),
    .head_o    (head)
  );

  assign cond_true_o = hit;
  assign cancel_o    = real_issue & head;
endmodule

// File: rtl/skip_cond_chk.sv
module skip_cond_chk #(
  parameter int unsigned MASK_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic              ext_word_i,
  input logic [1:0]        kind_i,
  input logic [3:0]        cond_i,
  input logic [MASK_W-1:0] skip_field_i,
  input logic              cond_true_o,
  input logic              cancel_o,
  input logic [MASK_W-1:0] mask_o
);
  p_never_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i == 4'b1110 |-> !cond_true_o);
  p_always_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i == 4'b1111 |-> cond_true_o);
  p_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !ext_word_i && kind_i == 2'd0 |=> mask_o == ($past(mask_o) >> 1));
  p_cancel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !ext_word_i && mask_o[0] |-> cancel_o);
  p_merge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !ext_word_i && !cancel_o && kind_i == 2'd1 && cond_true_o
    |=> mask_o == (($past(mask_o) >> 1) | $past(skip_field_i)));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !ext_word_i && !cancel_o && kind_i[1] |=> mask_o == '0);
  p_ext_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && ext_word_i |-> !cancel_o ##1 mask_o == $past(mask_o));
  p_dead_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |=> mask_o == ($past(mask_o) >> 1));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |-> !cancel_o ##1 $stable(mask_o));
endmodule

bind skip_cond_unit skip_cond_chk #(.MASK_W(MASK_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_i      (issue_i),
  .ext_word_i   (ext_word_i),
  .kind_i       (kind_i),
  .cond_i       (cond_i),
  .skip_field_i (skip_field_i),
  .cond_true_o  (cond_true_o),
  .cancel_o     (cancel_o),
  .mask_o       (mask_o)
);

// File: tb/tb_skip_cond_unit.sv
module tb_skip_cond_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0, ext = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [3:0] cond = 4'd0;
  logic [7:0] field = 8'd0;
  logic       fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
  logic       cond_true, cancel;
  logic [7:0] mask;

  int total = 0;
  int bad = 0;
  logic [7:0] m_mask = 8'd0;
  string      last_req = "R1";

  always #10 clk = ~clk;

  skip_cond_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .ext_word_i(ext),
    .kind_i(kind), .cond_i(cond), .skip_field_i(field),
    .flag_n_i(fn), .flag_z_i(fz), .flag_c_i(fc), .flag_v_i(fv),
    .cond_true_o(cond_true), .cancel_o(cancel), .mask_o(mask)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference for the condition
  function automatic logic ref_cond(input logic [3:0] c, input logic n, z, cy, v);
    logic p;
    case (c >> 1)
      0: p = z;
      1: p = cy;
      2: p = n;
      3: p = v;
      4: p = (n != v);
      5: p = z || (n != v);
      6: p = z || !cy;
      default: p = 1'b1;
    endcase
    return p == c[0];
  endfunction

  // one cycle: called just after a negedge
  task automatic step(input logic i, input logic e, input logic [1:0] k,
                      input logic [3:0] c, input logic [7:0] f, input logic [3:0] fl);
    logic exp_c, exp_x;
    string r;
    issue = i; ext = e; kind = k; cond = c; field = f;
    {fn, fz, fc, fv} = fl;
    #5;
    exp_c = ref_cond(c, fl[3], fl[2], fl[1], fl[0]);
    chk((c[3:1] == 3'd7) ? "R3" : "R2", {7'd0, cond_true}, {7'd0, exp_c});
    exp_x = i && !e && m_mask[0];
    r = !i ? "R10" : e ? "R8" : "R5";
    chk(r, {7'd0, cancel}, {7'd0, exp_x});
    if (!i) r = "R10";
    else if (e) r = "R8";
    else begin
      m_mask = m_mask >> 1;
      if (exp_x) r = "R9";
      else if (k == 2'd1) begin
        r = "R6";
        if (exp_c) m_mask = m_mask | f;
      end else if (k[1]) begin
        r = "R7";
        m_mask = 8'd0;
      end else r = "R4";
    end
    @(negedge clk);
    chk(r, mask, m_mask);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #15;
    chk("R1", mask, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", mask, 8'd0);

    // exhaustive condition table, idle cycles
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        step(1'b0, 1'b0, 2'd0, c[3:0], 8'hff, f[3:0]);

    // SKIP sets a window, plain instructions walk it out (R6, R4, R5)
    step(1, 0, 2'd1, 4'b1111, 8'b0000_0101, 4'h0);
    for (int j = 0; j < 4; j++) step(1, 0, 2'd0, 4'h0, 8'hff, 4'h0);

    // false SKIP only shifts (R6)
    step(1, 0, 2'd1, 4'b1110, 8'hff, 4'h0);
    chk("R6", mask, 8'd0);

    // AND chain with extension words in between (R6, R8, R9)
    step(1, 0, 2'd1, 4'b0001, 8'b0000_0010, 4'b0100); // Z set: true, marks 2nd after
    step(1, 1, 2'd0, 4'h0, 8'h00, 4'h0);              // extension word
    step(1, 0, 2'd0, 4'h0, 8'h00, 4'h0);
    step(1, 0, 2'd1, 4'b1111, 8'b0000_0001, 4'h0);    // cancelled true SKIP
    chk("R9", mask, 8'd0);
    step(1, 0, 2'd1, 4'b1111, 8'b1000_0001, 4'h0);
    step(1, 0, 2'd1, 4'b1111, 8'b0000_0110, 4'h0);    // cancelled: field ignored
    chk("R9", mask, 8'b0100_0000);

    // branch clears even with false condition; cancelled branch does not (R7, R9)
    step(1, 0, 2'd1, 4'b1111, 8'b0000_0110, 4'h0);
    step(1, 0, 2'd2, 4'b1110, 8'h00, 4'h0);
    chk("R7", mask, 8'd0);
    step(1, 0, 2'd1, 4'b1111, 8'b1000_0001, 4'h0);
    step(1, 0, 2'd3, 4'b1111, 8'h00, 4'h0);
    chk("R9", mask, 8'b0100_0000);
    step(1, 0, 2'd3, 4'b1111, 8'h00, 4'h0);
    chk("R7", mask, 8'd0);

    // idle holds a non-zero mask (R10)
    step(1, 0, 2'd1, 4'b1111, 8'b1010_1010, 4'h0);
    for (int j = 0; j < 3; j++) step(0, 0, 2'd1, 4'b1111, 8'hff, 4'h0);
    chk("R10", mask, 8'b1010_1010);

    // random stream
    for (int j = 0; j < 3000; j++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[0] | rv[1], rv[2] & rv[3] & rv[4], rv[6:5], rv[10:7], rv[18:11], rv[22:19]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule